// File: doc/BRIEF.md
# Byte-Lane Synchronous Dual-Port Memory

This block is a small two-port memory of 18-bit words, split into two 9-bit lanes. Both ports share one clock and act on its rising edge. Each port has its own address, write data, a pair of select inputs of opposite polarity, a read/write line, an active-low enable per lane, an output enable and a sleep input. On each edge a port reads or writes any mix of its two lanes. Both ports can reach every word at the same time.

Read timing is fixed when the block is elaborated. In the flow-through variant, data from a read sampled on an edge is presented right after that edge. In the pipelined variant, it is presented one edge later. Read data leaves each port as an 18-bit bus together with a 2-bit per-lane drive flag. A flag of 0 stands for a lane in high impedance, and the bus reads zero in such a lane. A surrounding pad ring or tri-state wrapper turns the flag into real output enables. Addresses come from outside the block.

Top module: `dpram_be_top`

## Requirements
- R1: A port is selected only when its active-low select is 0 and its active-high select is 1. A command sampled under any other combination writes nothing. In the flow-through variant it also leaves both lane drive flags at 0 after that edge.
- R2: Lane 1 is data bits 17:9 and lane 0 is bits 8:0. Lane enable bit n (active low) controls lane n. A selected write (read line 0) stores the write data into exactly those lanes whose enable is 0 and leaves the other lane of the word unchanged.
- R3: A selected read (read line 1) drives exactly those lanes whose enable is 0. Each driven lane presents the stored lane. With both enables at 1 the cycle is a no-operation and both lanes are undriven. A lane that is not driven reads zero on the data bus.
- R4: In the flow-through variant (PIPELINE = 0), data and drive flags from a read sampled on an edge appear after that same edge and stay until the next edge.
- R5: In the pipelined variant (PIPELINE = 1), data and drive flags from a read sampled on an edge appear after the following edge.
- R6: A selected write sampled on an edge leaves both drive flags of that port at 0 after that edge. In the pipelined variant this cancels a read result still in flight.
- R7: While a port's output enable is 1, both of its drive flags are 0 and its data bus is zero, with no clock edge needed. Lowering it presents the held read result at once.
- R8: Synchronous active-low reset clears every drive flag. Memory contents are not initialised.
- R9: While a port's sleep input is 1, that port ignores its commands: no write takes place, and its read path holds its outputs unchanged.
- R10: When both ports write the same word on the same edge, port 0's data is stored in each lane both enable. A lane enabled by only one port takes that port's data.
- R11: A read on one port and a write on the other port to the same word on the same edge return the data stored before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for both ports, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| p0_sel_n | input | 1 | Port 0 select, active low |
| p0_sel | input | 1 | Port 0 select, active high |
| p0_read | input | 1 | Port 0: 1 = read, 0 = write |
| p0_lane_n | input | NBYTES | Port 0 per-lane enables, active low |
| p0_out_en_n | input | 1 | Port 0 output enable, active low |
| p0_sleep | input | 1 | Port 0 sleep: commands ignored while 1 |
| p0_addr | input | ADDR_W | Port 0 word address |
| p0_wdata | input | NBYTES*BYTE_W | Port 0 write data |
| p0_rdata | output | NBYTES*BYTE_W | Port 0 read data, zero in undriven lanes |
| p0_drive | output | NBYTES | Port 0 per-lane drive flag (0 = high impedance) |
| p1_sel_n | input | 1 | Port 1 select, active low |
| p1_sel | input | 1 | Port 1 select, active high |
| p1_read | input | 1 | Port 1: 1 = read, 0 = write |
| p1_lane_n | input | NBYTES | Port 1 per-lane enables, active low |
| p1_out_en_n | input | 1 | Port 1 output enable, active low |
| p1_sleep | input | 1 | Port 1 sleep: commands ignored while 1 |
| p1_addr | input | ADDR_W | Port 1 word address |
| p1_wdata | input | NBYTES*BYTE_W | Port 1 write data |
| p1_rdata | output | NBYTES*BYTE_W | Port 1 read data, zero in undriven lanes |
| p1_drive | output | NBYTES | Port 1 per-lane drive flag (0 = high impedance) |

## Verification
A corrupted lane in the storage array stays hidden until that word is read back. It then shows as a wrong 9-bit field one edge after the read in flow-through timing, or two edges after it in pipelined timing. A wrong drive-flag register is visible much sooner. It shows on the next edge as a lane driven during a write, a deselect or a reset, or as a lane left floating after a read that enabled it. It also shows at once as a lane driven while the output enable is high. The collision cases are checked by reading the word back on the edge after the shared write. That read exposes a wrong lane priority, or read-after-write ordering, within one or two edges.

// File: rtl/dpram_be_pkg.sv
// Shared types for the byte-lane dual-port memory.
// Assumes: one command per port per clock edge.
package dpram_be_pkg;

    // Decoded per-port command for one clock edge.
    typedef enum logic [1:0] {
        CMD_IDLE  = 2'd0,   // deselected: nothing stored, nothing driven
        CMD_READ  = 2'd1,
        CMD_WRITE = 2'd2,
        CMD_HOLD  = 2'd3    // sleep: every register of the port keeps its value
    } cmd_e;

    // Port is selected only for the one mixed-polarity combination.
    function automatic logic port_selected(input logic sel_n, input logic sel);
        return (!sel_n) && sel;
    endfunction

endpackage

// File: rtl/dpram_be_port_ctrl.sv
// Command decoder for one port.
// Turns the raw select, read/write, lane-enable and sleep inputs into a
// command code and a per-lane write mask.
// Assumes: inputs are stable around the rising clock edge; purely combinational.
module dpram_be_port_ctrl
    import dpram_be_pkg::*;
#(
    parameter int NBYTES = 2
) (
    input  logic              sel_n,
    input  logic              sel,
    input  logic              read,
    input  logic [NBYTES-1:0] lane_on,
    input  logic              sleep,
    output cmd_e              cmd,
    output logic [NBYTES-1:0] wr_mask
);

    // Sleep overrides everything, then selection, then direction.
    always_comb begin
        if (sleep)
            cmd = CMD_HOLD;
        else if (!port_selected(sel_n, sel))
            cmd = CMD_IDLE;
        else if (read)
            cmd = CMD_READ;
        else
            cmd = CMD_WRITE;
    end

    // Lanes to store this edge: only enabled lanes of a selected write.
    always_comb begin
        wr_mask = (cmd == CMD_WRITE) ? lane_on : '0;
    end

endmodule

// File: rtl/dpram_be_array.sv
// Storage array with two write ports and two combinational read ports.
// A lane written by both ports on one edge takes port 0's data.
// Reads return the word as it stood before the current edge's writes,
// so a registered read on the same edge sees old data.
// Assumes: contents are not reset; DEPTH = 2**ADDR_W words.
module dpram_be_array #(
    parameter int ADDR_W = 6,
    parameter int BYTE_W = 9,
    parameter int NBYTES = 2,
    localparam int DATA_W = BYTE_W * NBYTES,
    localparam int DEPTH  = 1 << ADDR_W
) (
    input  logic              clk,
    input  logic [NBYTES-1:0] wr_mask0,
    input  logic [ADDR_W-1:0] addr0,
    input  logic [DATA_W-1:0] wdata0,
    input  logic [NBYTES-1:0] wr_mask1,
    input  logic [ADDR_W-1:0] addr1,
    input  logic [DATA_W-1:0] wdata1,
    output logic [DATA_W-1:0] rword0,
    output logic [DATA_W-1:0] rword1
);

    logic [DATA_W-1:0] mem [DEPTH];

    // Lane writes; port 0 is applied last so it wins a shared lane.
    always_ff @(posedge clk) begin
        for (int b = 0; b < NBYTES; b++) begin
            if (wr_mask1[b])
                mem[addr1][b*BYTE_W +: BYTE_W] <= wdata1[b*BYTE_W +: BYTE_W];
            if (wr_mask0[b])
                mem[addr0][b*BYTE_W +: BYTE_W] <= wdata0[b*BYTE_W +: BYTE_W];
        end
    end

    // Combinational read of the stored word for each port.
    assign rword0 = mem[addr0];
    assign rword1 = mem[addr1];

endmodule

// File: rtl/dpram_be_out_stage.sv
// Read output path for one port.
// Registers the read word and per-lane drive flags. With PIPELINE = 1 it adds a
// second register stage, whose flags a write clears on the edge it is sampled.
// The active-low output enable gates the flags combinationally. Undriven lanes
// read as zero.
// Assumes: CMD_HOLD freezes every register of the stage.
module dpram_be_out_stage
    import dpram_be_pkg::*;
#(
    parameter int BYTE_W   = 9,
    parameter int NBYTES   = 2,
    parameter bit PIPELINE = 1'b0,
    localparam int DATA_W  = BYTE_W * NBYTES
) (
    input  logic              clk,
    input  logic              rst_n,
    input  cmd_e              cmd,
    input  logic [NBYTES-1:0] lane_on,
    input  logic [DATA_W-1:0] rword,
    input  logic              out_en_n,
    output logic [DATA_W-1:0] rdata,
    output logic [NBYTES-1:0] drive
);

    logic [NBYTES-1:0] en1;
    logic [DATA_W-1:0] d1;
    logic [NBYTES-1:0] en_q;
    logic [DATA_W-1:0] d_q;

    // First stage: capture read word and the lanes a read enables.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en1 <= '0;
            d1  <= '0;
        end else if (cmd != CMD_HOLD) begin
            en1 <= (cmd == CMD_READ) ? lane_on : '0;
            d1  <= rword;
        end
    end

    generate
        if (PIPELINE) begin : g_pipe
            logic [NBYTES-1:0] en2;
            logic [DATA_W-1:0] d2;

            // Second stage: one more edge of latency; a write releases the lanes at once.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    en2 <= '0;
                    d2  <= '0;
                end else if (cmd != CMD_HOLD) begin
                    en2 <= (cmd == CMD_WRITE) ? '0 : en1;
                    d2  <= d1;
                end
            end

            assign en_q = en2;
            assign d_q  = d2;
        end else begin : g_flow
            assign en_q = en1;
            assign d_q  = d1;
        end
    endgenerate

    // Output enable gates the registered flags without waiting for a clock.
    assign drive = out_en_n ? '0 : en_q;

    // Zero each lane that is not driven.
    generate
        for (genvar b = 0; b < NBYTES; b++) begin : g_lane
            assign rdata[b*BYTE_W +: BYTE_W] = drive[b] ? d_q[b*BYTE_W +: BYTE_W] : '0;
        end
    endgenerate

endmodule

// File: rtl/dpram_be_top.sv
// Byte-lane synchronous dual-port memory, top level.
// Two identical ports, each with a command decoder and a read output stage,
// share one storage array. PIPELINE selects flow-through (0) or pipelined (1)
// read timing for both ports.
// Assumes: one shared clock; synchronous active-low reset clears the output
// path only.
module dpram_be_top
    import dpram_be_pkg::*;
#(
    parameter int ADDR_W   = 6,
    parameter int BYTE_W   = 9,
    parameter int NBYTES   = 2,
    parameter bit PIPELINE = 1'b0,
    localparam int DATA_W  = BYTE_W * NBYTES,
    localparam int NPORTS  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              p0_sel_n,
    input  logic              p0_sel,
    input  logic              p0_read,
    input  logic [NBYTES-1:0] p0_lane_n,
    input  logic              p0_out_en_n,
    input  logic              p0_sleep,
    input  logic [ADDR_W-1:0] p0_addr,
    input  logic [DATA_W-1:0] p0_wdata,
    output logic [DATA_W-1:0] p0_rdata,
    output logic [NBYTES-1:0] p0_drive,
    input  logic              p1_sel_n,
    input  logic              p1_sel,
    input  logic              p1_read,
    input  logic [NBYTES-1:0] p1_lane_n,
    input  logic              p1_out_en_n,
    input  logic              p1_sleep,
    input  logic [ADDR_W-1:0] p1_addr,
    input  logic [DATA_W-1:0] p1_wdata,
    output logic [DATA_W-1:0] p1_rdata,
    output logic [NBYTES-1:0] p1_drive
);

    logic              sel_n_a   [NPORTS];
    logic              sel_a     [NPORTS];
    logic              read_a    [NPORTS];
    logic [NBYTES-1:0] lane_on_a [NPORTS];
    logic              oe_n_a    [NPORTS];
    logic              sleep_a   [NPORTS];
    cmd_e              cmd_a     [NPORTS];
    logic [NBYTES-1:0] wmask_a   [NPORTS];
    logic [DATA_W-1:0] rword_a   [NPORTS];
    logic [DATA_W-1:0] rdata_a   [NPORTS];
    logic [NBYTES-1:0] drive_a   [NPORTS];

    // Gather the named port pins into per-port arrays.
    assign sel_n_a[0]   = p0_sel_n;
    assign sel_n_a[1]   = p1_sel_n;
    assign sel_a[0]     = p0_sel;
    assign sel_a[1]     = p1_sel;
    assign read_a[0]    = p0_read;
    assign read_a[1]    = p1_read;
    assign lane_on_a[0] = ~p0_lane_n;
    assign lane_on_a[1] = ~p1_lane_n;
    assign oe_n_a[0]    = p0_out_en_n;
    assign oe_n_a[1]    = p1_out_en_n;
    assign sleep_a[0]   = p0_sleep;
    assign sleep_a[1]   = p1_sleep;

    generate
        for (genvar p = 0; p < NPORTS; p++) begin : g_port
            dpram_be_port_ctrl #(
                .NBYTES (NBYTES)
            ) u_ctrl (
                .sel_n   (sel_n_a[p]),
                .sel     (sel_a[p]),
                .read    (read_a[p]),
                .lane_on (lane_on_a[p]),
                .sleep   (sleep_a[p]),
                .cmd     (cmd_a[p]),
                .wr_mask (wmask_a[p])
            );

            dpram_be_out_stage #(
                .BYTE_W   (BYTE_W),
                .NBYTES   (NBYTES),
                .PIPELINE (PIPELINE)
            ) u_out (
                .clk      (clk),
                .rst_n    (rst_n),
                .cmd      (cmd_a[p]),
                .lane_on  (lane_on_a[p]),
                .rword    (rword_a[p]),
                .out_en_n (oe_n_a[p]),
                .rdata    (rdata_a[p]),
                .drive    (drive_a[p])
            );
        end
    endgenerate

    dpram_be_array #(
        .ADDR_W (ADDR_W),
        .BYTE_W (BYTE_W),
        .NBYTES (NBYTES)
    ) u_array (
        .clk      (clk),
        .wr_mask0 (wmask_a[0]),
        .addr0    (p0_addr),
        .wdata0   (p0_wdata),
        .wr_mask1 (wmask_a[1]),
        .addr1    (p1_addr),
        .wdata1   (p1_wdata),
        .rword0   (rword_a[0]),
        .rword1   (rword_a[1])
    );

    // Scatter per-port results back to the named output pins.
    assign p0_rdata = rdata_a[0];
    assign p1_rdata = rdata_a[1];
    assign p0_drive = drive_a[0];
    assign p1_drive = drive_a[1];

endmodule

// File: rtl/dpram_be_chk.sv
// Protocol checker for the byte-lane dual-port memory, bound to the top.
// Watches only top-level pins. Keeps a history flag so that no property
// looks back past the last reset.
module dpram_be_chk #(
    parameter int BYTE_W   = 9,
    parameter int NBYTES   = 2,
    parameter bit PIPELINE = 1'b0,
    localparam int DATA_W  = BYTE_W * NBYTES
) (
    input logic              clk,
    input logic              rst_n,
    input logic              p0_sel_n,
    input logic              p0_sel,
    input logic              p0_read,
    input logic [NBYTES-1:0] p0_lane_n,
    input logic              p0_out_en_n,
    input logic              p0_sleep,
    input logic [DATA_W-1:0] p0_rdata,
    input logic [NBYTES-1:0] p0_drive,
    input logic              p1_sel_n,
    input logic              p1_sel,
    input logic              p1_read,
    input logic              p1_out_en_n,
    input logic              p1_sleep,
    input logic [NBYTES-1:0] p1_drive
);

    logic hist_ok;
    logic was_rst;

    // Marks that at least one full cycle has passed since reset.
    always_ff @(posedge clk) begin
        if (!rst_n) hist_ok <= 1'b0;
        else        hist_ok <= 1'b1;
    end

    // Remembers whether the previous edge was a reset edge.
    always_ff @(posedge clk) begin
        was_rst <= !rst_n;
    end

    AST_RESET_UNDRIVEN: assert property (@(posedge clk) disable iff (!rst_n)
        was_rst |-> (p0_drive == '0 && p1_drive == '0)); // R8

    AST_OE_GATES_P0: assert property (@(posedge clk) disable iff (!rst_n)
        p0_out_en_n |-> (p0_drive == '0 && p0_rdata == '0)); // R7

    AST_OE_GATES_P1: assert property (@(posedge clk) disable iff (!rst_n)
        p1_out_en_n |-> (p1_drive == '0)); // R7

    AST_WRITE_RELEASES_P0: assert property (@(posedge clk) disable iff (!rst_n)
        (hist_ok && $past(!p0_sleep && !p0_sel_n && p0_sel && !p0_read))
        |-> (p0_drive == '0)); // R6

    AST_WRITE_RELEASES_P1: assert property (@(posedge clk) disable iff (!rst_n)
        (hist_ok && $past(!p1_sleep && !p1_sel_n && p1_sel && !p1_read))
        |-> (p1_drive == '0)); // R6

    AST_SLEEP_HOLDS_P0: assert property (@(posedge clk) disable iff (!rst_n)
        (hist_ok && $past(p0_sleep) && $stable(p0_out_en_n))
        |-> ($stable(p0_drive) && $stable(p0_rdata))); // R9

    generate
        if (!PIPELINE) begin : g_flow_props
            AST_DESELECT_UNDRIVEN: assert property (@(posedge clk) disable iff (!rst_n)
                (hist_ok && $past(!p0_sleep && !(!p0_sel_n && p0_sel)))
                |-> (p0_drive == '0)); // R1

            AST_LANE_ENABLE_RESPECTED: assert property (@(posedge clk) disable iff (!rst_n)
                (hist_ok && $past(!p0_sleep))
                |-> ((p0_drive & $past(p0_lane_n)) == '0)); // R3
        end
    endgenerate

endmodule

bind dpram_be_top dpram_be_chk #(
    .BYTE_W   (BYTE_W),
    .NBYTES   (NBYTES),
    .PIPELINE (PIPELINE)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .p0_sel_n    (p0_sel_n),
    .p0_sel      (p0_sel),
    .p0_read     (p0_read),
    .p0_lane_n   (p0_lane_n),
    .p0_out_en_n (p0_out_en_n),
    .p0_sleep    (p0_sleep),
    .p0_rdata    (p0_rdata),
    .p0_drive    (p0_drive),
    .p1_sel_n    (p1_sel_n),
    .p1_sel      (p1_sel),
    .p1_read     (p1_read),
    .p1_out_en_n (p1_out_en_n),
    .p1_sleep    (p1_sleep),
    .p1_drive    (p1_drive)
);

// File: tb/tb_dpram_be_top.sv
// Testbench for dpram_be_top: one flow-through instance (dut) and one
// pipelined instance (dut_pipe) share all inputs. A vector table drives
// port 0, then directed tests cover sleep, collisions, pipelining, output
// enable and reset.
module tb_dpram_be_top;

    localparam int CLK_PERIOD = 10;
    localparam int AW = 6;
    localparam int BW = 9;
    localparam int NB = 2;
    localparam int DW = BW * NB;
    localparam int NVEC = 11;

    typedef struct packed {
        logic          sel_n;
        logic          sel;
        logic          read;
        logic [NB-1:0] lane_n;
        logic          oe_n;
        logic [AW-1:0] addr;
        logic [DW-1:0] wdata;
        logic [NB-1:0] raw_en;   // flow lanes enabled, before output enable
        logic [DW-1:0] raw_word; // stored word that the read returns
    } vec_t;

    // Port 0 sequence on word 5; expectations follow R1-style rules by hand.
    localparam vec_t VECS [NVEC] = '{
        '{1'b0, 1'b1, 1'b0, 2'b00, 1'b0, 6'd5, 18'h15A5A, 2'b00, 18'h00000}, // full write
        '{1'b0, 1'b1, 1'b1, 2'b00, 1'b0, 6'd5, 18'h00000, 2'b11, 18'h15A5A}, // full read
        '{1'b0, 1'b1, 1'b0, 2'b01, 1'b0, 6'd5, 18'h3FFFF, 2'b00, 18'h00000}, // lane 1 write
        '{1'b0, 1'b1, 1'b1, 2'b10, 1'b0, 6'd5, 18'h00000, 2'b01, 18'h3FE5A}, // lane 0 read
        '{1'b0, 1'b1, 1'b1, 2'b01, 1'b0, 6'd5, 18'h00000, 2'b10, 18'h3FE5A}, // lane 1 read
        '{1'b0, 1'b1, 1'b1, 2'b11, 1'b0, 6'd5, 18'h00000, 2'b00, 18'h3FE5A}, // no lanes
        '{1'b1, 1'b1, 1'b0, 2'b00, 1'b0, 6'd5, 18'h00000, 2'b00, 18'h00000}, // deselected write
        '{1'b0, 1'b0, 1'b0, 2'b00, 1'b0, 6'd5, 18'h00000, 2'b00, 18'h00000}, // deselected write
        '{1'b0, 1'b1, 1'b1, 2'b00, 1'b1, 6'd5, 18'h00000, 2'b11, 18'h3FE5A}, // read, oe high
        '{1'b0, 1'b1, 1'b1, 2'b00, 1'b0, 6'd5, 18'h00000, 2'b11, 18'h3FE5A}, // read
        '{1'b1, 1'b0, 1'b1, 2'b00, 1'b0, 6'd5, 18'h00000, 2'b00, 18'h00000}  // deselected read
    };

    logic          clk = 1'b0;
    logic          rst_n;
    logic          p0_sel_n, p0_sel, p0_read, p0_out_en_n, p0_sleep;
    logic [NB-1:0] p0_lane_n;
    logic [AW-1:0] p0_addr;
    logic [DW-1:0] p0_wdata;
    logic          p1_sel_n, p1_sel, p1_read, p1_out_en_n, p1_sleep;
    logic [NB-1:0] p1_lane_n;
    logic [AW-1:0] p1_addr;
    logic [DW-1:0] p1_wdata;
    logic [DW-1:0] f0_rdata, f1_rdata, q0_rdata, q1_rdata;
    logic [NB-1:0] f0_drive, f1_drive, q0_drive, q1_drive;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    dpram_be_top #(.ADDR_W(AW), .BYTE_W(BW), .NBYTES(NB), .PIPELINE(1'b0)) dut (
        .clk(clk), .rst_n(rst_n),
        .p0_sel_n(p0_sel_n), .p0_sel(p0_sel), .p0_read(p0_read), .p0_lane_n(p0_lane_n),
        .p0_out_en_n(p0_out_en_n), .p0_sleep(p0_sleep), .p0_addr(p0_addr),
        .p0_wdata(p0_wdata), .p0_rdata(f0_rdata), .p0_drive(f0_drive),
        .p1_sel_n(p1_sel_n), .p1_sel(p1_sel), .p1_read(p1_read), .p1_lane_n(p1_lane_n),
        .p1_out_en_n(p1_out_en_n), .p1_sleep(p1_sleep), .p1_addr(p1_addr),
        .p1_wdata(p1_wdata), .p1_rdata(f1_rdata), .p1_drive(f1_drive)
    );

    dpram_be_top #(.ADDR_W(AW), .BYTE_W(BW), .NBYTES(NB), .PIPELINE(1'b1)) dut_pipe (
        .clk(clk), .rst_n(rst_n),
        .p0_sel_n(p0_sel_n), .p0_sel(p0_sel), .p0_read(p0_read), .p0_lane_n(p0_lane_n),
        .p0_out_en_n(p0_out_en_n), .p0_sleep(p0_sleep), .p0_addr(p0_addr),
        .p0_wdata(p0_wdata), .p0_rdata(q0_rdata), .p0_drive(q0_drive),
        .p1_sel_n(p1_sel_n), .p1_sel(p1_sel), .p1_read(p1_read), .p1_lane_n(p1_lane_n),
        .p1_out_en_n(p1_out_en_n), .p1_sleep(p1_sleep), .p1_addr(p1_addr),
        .p1_wdata(p1_wdata), .p1_rdata(q1_rdata), .p1_drive(q1_drive)
    );

    // Zero the lanes whose drive flag is clear.
    function automatic logic [DW-1:0] lane_mask(input logic [NB-1:0] en, input logic [DW-1:0] w);
        logic [DW-1:0] r;
        for (int b = 0; b < NB; b++)
            r[b*BW +: BW] = en[b] ? w[b*BW +: BW] : '0;
        return r;
    endfunction

    task automatic check(input string req, input logic [NB-1:0] act_en, input logic [DW-1:0] act_d,
                         input logic [NB-1:0] exp_en, input logic [DW-1:0] exp_w);
        logic [DW-1:0] exp_d;
        exp_d = lane_mask(exp_en, exp_w);
        checks++;
        if (act_en !== exp_en || act_d !== exp_d) begin
            errors++;
            $display("FAIL %s: drive=%b data=%h expected drive=%b data=%h",
                     req, act_en, act_d, exp_en, exp_d);
        end
    endtask

    task automatic p0_set(input logic sn, input logic s, input logic rd, input logic [NB-1:0] ln,
                          input logic oe, input logic [AW-1:0] a, input logic [DW-1:0] wd);
        p0_sel_n = sn; p0_sel = s; p0_read = rd; p0_lane_n = ln;
        p0_out_en_n = oe; p0_addr = a; p0_wdata = wd;
    endtask

    task automatic p1_set(input logic sn, input logic s, input logic rd, input logic [NB-1:0] ln,
                          input logic oe, input logic [AW-1:0] a, input logic [DW-1:0] wd);
        p1_sel_n = sn; p1_sel = s; p1_read = rd; p1_lane_n = ln;
        p1_out_en_n = oe; p1_addr = a; p1_wdata = wd;
    endtask

    // One rising edge, then come back to the falling edge to sample.
    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    // Watchdog: a hung run is a failed check and still prints the summary.
    initial begin
        repeat (5000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: run did not finish, actual=hung expected=done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [NB-1:0] prev_en;
        logic [DW-1:0] prev_w;
        rst_n = 1'b0;
        p0_sleep = 1'b0;
        p1_sleep = 1'b0;
        p0_set(1'b1, 1'b0, 1'b1, 2'b11, 1'b0, '0, '0);
        p1_set(1'b1, 1'b0, 1'b1, 2'b11, 1'b0, '0, '0);
        step();
        step();
        check("R8 reset flow", f0_drive, f0_rdata, 2'b00, '0);
        check("R8 reset pipe", q0_drive, q0_rdata, 2'b00, '0);
        rst_n = 1'b1;

        // Vector table on port 0 (R1, R2, R3, R4, R5, R6, R7).
        prev_en = '0;
        prev_w  = '0;
        for (int i = 0; i < NVEC; i++) begin
            logic wr_sel;
            p0_set(VECS[i].sel_n, VECS[i].sel, VECS[i].read, VECS[i].lane_n,
                   VECS[i].oe_n, VECS[i].addr, VECS[i].wdata);
            step();
            wr_sel = !VECS[i].sel_n && VECS[i].sel && !VECS[i].read;
            check($sformatf("R4 R2 R3 R1 R7 flow vector %0d", i), f0_drive, f0_rdata,
                  VECS[i].oe_n ? 2'b00 : VECS[i].raw_en, VECS[i].raw_word);
            check($sformatf("R5 R6 R7 pipe vector %0d", i), q0_drive, q0_rdata,
                  (wr_sel || VECS[i].oe_n) ? 2'b00 : prev_en, prev_w);
            prev_en = VECS[i].raw_en;
            prev_w  = VECS[i].raw_word;
        end

        // R9: sleep blocks a write and holds the outputs.
        p0_set(1'b0, 1'b1, 1'b1, 2'b00, 1'b0, 6'd5, '0);
        step();
        check("R4 read before sleep", f0_drive, f0_rdata, 2'b11, 18'h3FE5A);
        p0_sleep = 1'b1;
        p0_set(1'b0, 1'b1, 1'b0, 2'b00, 1'b0, 6'd5, 18'h00000);
        step();
        check("R9 sleep holds flow output", f0_drive, f0_rdata, 2'b11, 18'h3FE5A);
        p0_sleep = 1'b0;
        p0_set(1'b0, 1'b1, 1'b1, 2'b00, 1'b0, 6'd5, '0);
        step();
        check("R9 write during sleep ignored", f0_drive, f0_rdata, 2'b11, 18'h3FE5A);
        check("R9 pipe stage held across sleep", q0_drive, q0_rdata, 2'b11, 18'h3FE5A);

        // R10: same-word writes from both ports.
        p0_set(1'b0, 1'b1, 1'b0, 2'b10, 1'b0, 6'd7, 18'h00011);
        p1_set(1'b0, 1'b1, 1'b0, 2'b00, 1'b0, 6'd7, 18'h3FFFF);
        step();
        p0_set(1'b0, 1'b1, 1'b0, 2'b00, 1'b0, 6'd8, 18'h12345);
        p1_set(1'b0, 1'b1, 1'b0, 2'b00, 1'b0, 6'd8, 18'h2BCDE);
        step();
        p0_set(1'b0, 1'b1, 1'b1, 2'b00, 1'b0, 6'd7, '0);
        p1_set(1'b1, 1'b0, 1'b1, 2'b11, 1'b0, '0, '0);
        step();
        check("R10 mixed lanes, port 0 wins shared lane", f0_drive, f0_rdata, 2'b11, 18'h3FE11);
        p0_set(1'b0, 1'b1, 1'b1, 2'b00, 1'b0, 6'd8, '0);
        step();
        check("R10 both lanes shared, port 0 wins", f0_drive, f0_rdata, 2'b11, 18'h12345);

        // R11: read on port 0 and write on port 1, same word, same edge.
        p0_set(1'b0, 1'b1, 1'b1, 2'b00, 1'b0, 6'd7, '0);
        p1_set(1'b0, 1'b1, 1'b0, 2'b00, 1'b0, 6'd7, 18'h00000);
        step();
        check("R11 read returns old data", f0_drive, f0_rdata, 2'b11, 18'h3FE11);
        check("R6 port 1 write leaves lanes undriven", f1_drive, f1_rdata, 2'b00, '0);
        p0_set(1'b1, 1'b0, 1'b1, 2'b11, 1'b0, '0, '0);
        p1_set(1'b0, 1'b1, 1'b1, 2'b00, 1'b0, 6'd7, '0);
        step();
        check("R11 port 1 write landed after the edge", f1_drive, f1_rdata, 2'b11, 18'h00000);
        p1_set(1'b1, 1'b0, 1'b1, 2'b11, 1'b0, '0, '0);

        // R5 and R6: pipelined latency and write release.
        p0_set(1'b0, 1'b1, 1'b1, 2'b00, 1'b0, 6'd8, '0);
        step();
        check("R5 pipe not yet valid", q0_drive, q0_rdata, 2'b00, '0);
        check("R4 flow valid same edge", f0_drive, f0_rdata, 2'b11, 18'h12345);
        p0_set(1'b1, 1'b0, 1'b1, 2'b11, 1'b0, '0, '0);
        step();
        check("R5 pipe valid one edge later", q0_drive, q0_rdata, 2'b11, 18'h12345);
        check("R1 flow deselect undriven", f0_drive, f0_rdata, 2'b00, '0);
        p0_set(1'b0, 1'b1, 1'b1, 2'b00, 1'b0, 6'd8, '0);
        step();
        p0_set(1'b0, 1'b1, 1'b0, 2'b00, 1'b0, 6'd9, 18'h00001);
        step();
        check("R6 pipe write cancels in-flight read", q0_drive, q0_rdata, 2'b00, '0);

        // R7: output enable acts without a clock edge.
        p0_set(1'b0, 1'b1, 1'b1, 2'b00, 1'b0, 6'd8, '0);
        step();
        p0_set(1'b1, 1'b0, 1'b1, 2'b11, 1'b1, '0, '0);
        step();
        check("R7 pipe oe high undriven", q0_drive, q0_rdata, 2'b00, '0);
        p0_out_en_n = 1'b0;
        #1;
        check("R7 pipe oe low drives at once", q0_drive, q0_rdata, 2'b11, 18'h12345);

        // R8: reset in mid-run clears lanes held by an earlier read.
        p0_set(1'b0, 1'b1, 1'b1, 2'b00, 1'b0, 6'd8, '0);
        step();
        rst_n = 1'b0;
        step();
        check("R8 mid-run reset flow", f0_drive, f0_rdata, 2'b00, '0);
        check("R8 mid-run reset pipe", q0_drive, q0_rdata, 2'b00, '0);
        rst_n = 1'b1;
        step();

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule